// File: doc/BRIEF.md
# Mailbox Byte-Stream Producer Channel

This block moves a stream of bytes from a local producer to a consumer across a pair of shared mailbox registers. Bytes arrive on a push interface and wait in a 128-entry first-in, first-out buffer. A full flag warns the producer that the buffer has no room. One mailbox register carries the byte in flight. A second register carries a status code.

There is no ready/valid handshake. An internal down-counter, reloaded from a 16-bit value, produces a periodic poll tick, and the busy bit of the status register is examined only on that tick. If the consumer has cleared the busy bit, the next byte is placed in the data register and the status becomes 0x03. If nothing is waiting, the status becomes 0x00 to mark the channel idle. The consumer detects 0x03, takes the data byte and writes the status register back with bit 1 cleared.

A global enable freezes the whole channel when it is low. Pushes are discarded, consumer writes are ignored and the timer stops.

Top module: `mbox_stream_tx`

## Requirements
- R1: After reset, the data register reads 0x00, the status register reads 0x00, and `full` and `overflow` are both 0.
- R2: A push with `en` high and `full` low is accepted. `full` is 1 exactly when 128 accepted bytes have not yet been loaded into the data register.
- R3: A push with `en` high while `full` is 1 is dropped and sets `overflow`. `overflow` stays at 1 until reset.
- R4: The poll timer counts down once per enabled cycle. When it reaches zero, a tick occurs and the timer reloads from `tick_reload`. This gives one tick every `tick_reload`+1 enabled cycles, and the first tick falls in the first enabled cycle after reset.
- R5: On a tick where status bit 1 is 0 and the buffer holds a byte, the oldest byte is written to the data register and the status becomes 0x03 at that clock edge.
- R6: On a tick where status bit 1 is 0 and the buffer is empty, the status becomes 0x00.
- R7: On a tick where status bit 1 is 1, no byte is loaded and the data register keeps its value.
- R8: When `en` is high and `cons_wr` is high, the status register takes the value of `cons_wdata`. The exception is a tick that acts under R5 or R6 on the same edge; in that case the tick's update wins.
- R9: While `en` is low, pushes are dropped without setting `overflow`, consumer writes are ignored, the timer holds its value, and the data and status registers do not change.
- R10: The bytes appear in the data register in the same order in which they were accepted, and none is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global channel enable |
| push_valid | input | 1 | Push strobe for one byte |
| push_data | input | 8 | Byte to push |
| full | output | 1 | Buffer holds 128 bytes |
| overflow | output | 1 | Sticky flag: a push was dropped because the buffer was full |
| tick_reload | input | 16 | Reload value of the poll timer |
| cons_wr | input | 1 | Consumer write strobe for the status register |
| cons_wdata | input | 8 | Value the consumer writes to the status register |
| data_reg | output | 8 | Mailbox data register |
| status_reg | output | 8 | Mailbox status register |

## Verification
The assertions assume that the consumer writes the status register only after it has seen 0x03, or while the busy bit is already clear. They also assume that `en` changes only between clock edges. The bench meets these assumptions with a consumer model that responds to 0x03 by writing back 0x01. In one phase, extra stray status writes are added, and they are issued only while bit 1 is clear. That phase deliberately lets some of those stray writes land on the same edge as a tick, which exercises the priority rule of R8. The enable is toggled only while the consumer model is quiet, so that no byte handover is split across an enable change.

// File: rtl/mbox_stream_tx.sv
module mbox_stream_tx #(
  parameter int DEPTH  = 128,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              push_valid,
  input  logic [7:0]        push_data,
  output logic              full,
  output logic              overflow,
  input  logic [TICK_W-1:0] tick_reload,
  input  logic              cons_wr,
  input  logic [7:0]        cons_wdata,
  output logic [7:0]        data_reg,
  output logic [7:0]        status_reg
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BUSY  = 1;
  localparam logic [7:0] ST_PEND = 8'h03;
  localparam logic [7:0] ST_IDLE = 8'h00;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [7:0]        mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [TICK_W-1:0] tick_cnt;

  logic tick, push_ok, poll, load, idle;

  assign full    = count == CNT_W'(DEPTH);
  assign tick    = en && (tick_cnt == '0);
  assign push_ok = en && push_valid && !full;
  assign poll    = tick && !status_reg[BUSY];
  assign load    = poll && (count != '0);
  assign idle    = poll && (count == '0);

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      tick_cnt   <= '0;
      overflow   <= 1'b0;
      data_reg   <= 8'h00;
      status_reg <= ST_IDLE;
    end else if (en) begin
      tick_cnt <= tick ? tick_reload : tick_cnt - 1'b1;
      if (push_ok)
        wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (push_valid && full)
        overflow <= 1'b1;
      count <= count + CNT_W'(push_ok) - CNT_W'(load);
      if (load) begin
        data_reg   <= mem[rd_ptr];
        status_reg <= ST_PEND;
        rd_ptr     <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      end else if (idle)
        status_reg <= ST_IDLE;
      else if (cons_wr)
        status_reg <= cons_wdata;
    end
  end

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(data_reg) && $stable(status_reg) && $stable(overflow)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    en && push_valid && full && !load |=> full && overflow); // R3
  AST_LOAD_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    en && tick && !status_reg[BUSY] && count != '0 |=> status_reg == ST_PEND); // R5
  AST_DATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_reg) |-> status_reg == ST_PEND); // R5
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    en && tick && !status_reg[BUSY] && count == '0 |=> status_reg == ST_IDLE); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && tick && status_reg[BUSY] && !cons_wr |=> $stable(data_reg) && $stable(status_reg)); // R7
  AST_CONS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    en && cons_wr && !poll |=> status_reg == $past(cons_wdata)); // R8
endmodule

// File: tb/tb_mbox_stream_tx.sv
`timescale 1ns/1ps
module tb_mbox_stream_tx;
  logic clk = 0, rst_n = 0, en = 0, push_valid = 0, cons_wr = 0;
  logic [7:0] push_data = 0, cons_wdata = 0;
  logic [15:0] tick_reload = 16'd3;
  logic full, overflow;
  logic [7:0] data_reg, status_reg;

  mbox_stream_tx dut (.clk(clk), .rst_n(rst_n), .en(en), .push_valid(push_valid),
    .push_data(push_data), .full(full), .overflow(overflow), .tick_reload(tick_reload),
    .cons_wr(cons_wr), .cons_wdata(cons_wdata), .data_reg(data_reg), .status_reg(status_reg));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, cons_mode = 0;
  logic [7:0] mq[$], sent[$], got[$];
  logic [7:0] m_data = 0, m_status = 0;
  logic m_ovf = 0;
  int m_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_data = 0; m_status = 0; m_ovf = 0; m_cnt = 0;
    end else if (en) begin
      bit tk, was_full;
      tk = (m_cnt == 0);
      m_cnt = tk ? int'(tick_reload) : m_cnt - 1;
      was_full = (mq.size() == 128);
      if (tk && !m_status[1] && mq.size() > 0) begin
        m_data = mq.pop_front(); m_status = 8'h03;
      end else if (tk && !m_status[1]) m_status = 8'h00;
      else if (cons_wr) m_status = cons_wdata;
      if (push_valid) begin
        if (was_full) m_ovf = 1;
        else begin mq.push_back(push_data); sent.push_back(push_data); end
      end
    end
  end

  // per-cycle compare and consumer model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(data_reg == m_data, "R4 R5 R7 R10 data_reg", data_reg, m_data);
      chk(status_reg == m_status, "R5 R6 R7 R8 status_reg", status_reg, m_status);
      chk(full == (mq.size() == 128), "R2 full", full, mq.size() == 128);
      chk(overflow == m_ovf, "R3 overflow", overflow, m_ovf);
    end
    cons_wr = 0;
    if (cons_mode == 1 || cons_mode == 4 || (cons_mode == 2 && $urandom % 8 == 0)) begin
      if (status_reg == 8'h03) begin
        cons_wr = 1; cons_wdata = status_reg & ~8'h02; got.push_back(data_reg);
      end else if (cons_mode == 4 && !status_reg[1] && $urandom % 2 == 0) begin
        cons_wr = 1; cons_wdata = 8'h80;
      end
    end else if (cons_mode == 3) begin
      cons_wr = 1; cons_wdata = 8'h01;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic push_n(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); push_valid = 1; push_data = 8'($urandom);
      @(negedge clk); push_valid = 0;
      repeat (gap == 0 ? 0 : $urandom % gap) @(negedge clk);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (mq.size() == 0 && status_reg == 8'h00) break;
    end
    #1 chk(status_reg == 8'h00, "R6 idle after drain", status_reg, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(data_reg == 0 && status_reg == 0, "R1 reset registers", {data_reg, status_reg}, 0);
    chk(!full && !overflow, "R1 reset flags", {full, overflow}, 0);
    rst_n = 1; en = 1;

    cons_mode = 1; tick_reload = 16'd3;
    push_n(20, 4); drain();

    cons_mode = 2; tick_reload = 16'd0;
    push_n(30, 2); drain();

    cons_mode = 0; tick_reload = 16'd7;
    @(negedge clk); push_valid = 1;
    for (int i = 0; i < 140; i++) begin push_data = 8'(i); @(negedge clk); end
    push_valid = 0;
    chk(full == 1, "R2 full after 140 pushes", full, 1);
    chk(overflow == 1, "R3 overflow after push to full", overflow, 1);

    begin
      logic [7:0] d0, s0;
      @(negedge clk); en = 0; cons_mode = 3;
      d0 = data_reg; s0 = status_reg;
      push_valid = 1; push_data = 8'h5a;
      repeat (20) @(negedge clk);
      push_valid = 0; cons_mode = 0;
      repeat (2) @(negedge clk);
      chk(data_reg == d0, "R9 data held while disabled", data_reg, d0);
      chk(status_reg == s0, "R9 status held while disabled", status_reg, s0);
      chk(full == 1 && overflow == 1, "R9 flags held while disabled", {full, overflow}, 3);
      en = 1;
    end
    @(negedge clk); cons_mode = 1; drain();

    cons_mode = 4; tick_reload = 16'd2;
    push_n(25, 6);
    cons_mode = 1; drain();

    chk(got.size() == sent.size(), "R10 byte count", got.size(), sent.size());
    for (int i = 0; i < got.size() && i < sent.size(); i++)
      chk(got[i] == sent[i], "R10 byte order", got[i], sent[i]);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule